// File: doc/BRIEF.md
# Quadrature Input Qualifier

This block sits between the four pins of a quadrature encoder (channel A, channel B, index and strobe) and the position decoder that counts them. Every input first crosses into the peripheral clock domain through a two-stage synchronizer. Each input then has its own selection. It can be forwarded straight from the synchronizer, passed through a digital glitch filter, or forced low.

The glitch filter accepts a new level only after the synchronized input has held that level for a programmed number of consecutive clock cycles. Shorter disturbances are discarded. Because of the synchronizer, any input edge needs at least two clock cycles to be seen. With the filter in use, it needs two cycles plus the filter width.

The block also watches the qualified A and B signals. If both change in the same clock cycle, that is an illegal quadrature step. The block then raises a sticky phase-error flag, which holds until a clear pulse arrives.

Top module: `qep_input_qual`

## Requirements
- R1: While reset is asserted and right after it, all four qualified outputs and the phase-error flag are 0.
- R2: On the synchronized-only path, a qualified output equals its raw input delayed by exactly two clock edges.
- R3: When the primary select bit of a channel is 1, the synchronized-only path is used whatever the secondary bit is, so a one-cycle pulse passes even with a large filter width.
- R4: When the primary select bit is 0 and the secondary bit is 1, the filtered path is used.
- R5: When both select bits of a channel are 0, its qualified output stays 0 whatever the raw input does.
- R6: The filter changes its output to a new level only after the synchronized input has held that level for W consecutive cycles (W = filter width, 1 to 255). The new level appears 2+W clock edges after the raw change. A pulse shorter than W cycles does not reach the output.
- R7: A filter width of 0 behaves exactly like a width of 1.
- R8: If qualified A (bit 0) and qualified B (bit 1) change in the same cycle, the phase-error flag rises one clock edge later.
- R9: The phase-error flag stays set until an error-clear pulse is sampled, and it reads 0 after that edge. If a new simultaneous A/B change is sampled at that same edge, setting wins and the flag stays 1.
- R10: A change of only A, only B, A and B in different cycles, or any activity on index (bit 2) or strobe (bit 3) never sets the phase-error flag.
- R11: Each channel follows its own select bits, so channels in different modes show their own latencies at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | NUM_CH | Raw encoder inputs: bit 0 A, bit 1 B, bit 2 index, bit 3 strobe |
| sel_direct | input | NUM_CH | Primary select per channel; 1 selects the synchronized-only path |
| sel_filter | input | NUM_CH | Secondary select per channel; with primary 0, a 1 selects the filtered path |
| filt_width | input | CNT_W | Number of stable cycles the filter requires (0 is treated as 1) |
| err_clr | input | 1 | One-cycle pulse that clears the phase-error flag |
| qual_out | output | NUM_CH | Qualified inputs for the decoder |
| phase_err | output | 1 | Sticky flag for a simultaneous A/B change |

## Verification
Timing is counted in clock edges after a raw input changes:
- A synchronized-only output is due 2 edges later.
- A filtered output is due 2+W edges later.
- The phase-error flag is due 3 edges after a simultaneous A/B change on the direct path.

The bench drives inputs on falling edges and samples on falling edges. It checks each result in the cycle it is due, and it also checks the cycle before, so a result that arrives one cycle early or late is caught. The filter is swept over widths 1 to 6 and pulse lengths 1 to W+1, and the expected pass or reject outcome is computed from L >= W.

// File: rtl/qiq_pkg.sv
package qiq_pkg;
    localparam int CH_A      = 0;
    localparam int CH_B      = 1;
    localparam int CH_INDEX  = 2;
    localparam int CH_STROBE = 3;

    typedef enum logic [1:0] {
        PATH_OFF    = 2'd0,
        PATH_DIRECT = 2'd1,
        PATH_FILTER = 2'd2
    } path_e;

    function automatic path_e pick_path(input logic primary, input logic secondary);
        if (primary)        return PATH_DIRECT;
        else if (secondary) return PATH_FILTER;
        else                return PATH_OFF;
    endfunction
endpackage

// File: rtl/qiq_sync.sv
module qiq_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;
endmodule

// File: rtl/qiq_glitch_filter.sv
module qiq_glitch_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_in,
    input  logic [CNT_W-1:0] width,
    output logic             level_out
);
    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] run;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic [CNT_W:0] run_next;
    logic [CNT_W:0] limit;

    always_comb begin
        st_d     = st_q;
        run_next = {1'b0, st_q.run} + 1'b1;
        limit    = (width == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, width};
        if (level_in == st_q.level) begin
            st_d.run = '0;
        end else if (run_next >= limit) begin
            st_d.level = level_in;
            st_d.run   = '0;
        end else begin
            st_d.run = run_next[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_out = st_q.level;
endmodule

// File: rtl/qiq_phase_mon.sv
module qiq_phase_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic qa,
    input  logic qb,
    input  logic clr,
    output logic err
);
    typedef struct packed {
        logic prev_a;
        logic prev_b;
        logic flag;
    } phase_state_t;

    phase_state_t st_d, st_q;
    logic both_moved;

    always_comb begin
        st_d        = st_q;
        both_moved  = (qa != st_q.prev_a) && (qb != st_q.prev_b);
        st_d.prev_a = qa;
        st_d.prev_b = qb;
        if (both_moved)  st_d.flag = 1'b1;
        else if (clr)    st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err = st_q.flag;
endmodule

// File: rtl/qep_input_qual.sv
module qep_input_qual
    import qiq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] raw_in,
    input  logic [NUM_CH-1:0] sel_direct,
    input  logic [NUM_CH-1:0] sel_filter,
    input  logic [CNT_W-1:0]  filt_width,
    input  logic              err_clr,
    output logic [NUM_CH-1:0] qual_out,
    output logic              phase_err
);
    logic [NUM_CH-1:0] synced;
    logic [NUM_CH-1:0] filtered;

    qiq_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (synced)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        qiq_glitch_filter #(.CNT_W(CNT_W)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_in  (synced[ch]),
            .width     (filt_width),
            .level_out (filtered[ch])
        );

        always_comb begin
            unique case (pick_path(sel_direct[ch], sel_filter[ch]))
                PATH_DIRECT: qual_out[ch] = synced[ch];
                PATH_FILTER: qual_out[ch] = filtered[ch];
                default:     qual_out[ch] = 1'b0;
            endcase
        end
    end

    qiq_phase_mon u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .qa    (qual_out[CH_A]),
        .qb    (qual_out[CH_B]),
        .clr   (err_clr),
        .err   (phase_err)
    );
endmodule

// File: rtl/qep_input_qual_chk.sv
module qep_input_qual_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] raw_in,
    input logic [NUM_CH-1:0] sel_direct,
    input logic [NUM_CH-1:0] sel_filter,
    input logic              err_clr,
    input logic [NUM_CH-1:0] qual_out,
    input logic              phase_err
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R5
    off_is_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_out & ~(sel_direct | sel_filter)) == '0);

    // R2
    direct_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> ((qual_out & sel_direct) == ($past(raw_in, 2) & sel_direct)));

    // R8
    phase_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$stable(qual_out[0]) && !$stable(qual_out[1])) |=> phase_err);

    // R9
    phase_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_err && !err_clr) |=> phase_err);

    // R9
    phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && ($stable(qual_out[0]) || $stable(qual_out[1]))) |=> !phase_err);
endmodule

bind qep_input_qual qep_input_qual_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_in     (raw_in),
    .sel_direct (sel_direct),
    .sel_filter (sel_filter),
    .err_clr    (err_clr),
    .qual_out   (qual_out),
    .phase_err  (phase_err)
);

// File: tb/qep_input_qual_bench.sv
module qep_input_qual_bench;
    localparam int NUM_CH = 4;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] sel_direct;
    logic [NUM_CH-1:0] sel_filter;
    logic [CNT_W-1:0]  filt_width;
    logic              err_clr;
    logic [NUM_CH-1:0] qual_out;
    logic              phase_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    qep_input_qual #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_qep_input_qual (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .sel_direct(sel_direct),
        .sel_filter(sel_filter), .filt_width(filt_width), .err_clr(err_clr),
        .qual_out(qual_out), .phase_err(phase_err)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] prev;
        rst_n = 1'b0; raw_in = '0; sel_direct = '0; sel_filter = '0;
        filt_width = 8'd1; err_clr = 1'b0;
        tick(3);
        check("R1 outputs in reset", {27'd0, phase_err, qual_out}, 32'd0);
        rst_n = 1'b1;
        tick(1);
        check("R1 outputs after reset", {27'd0, phase_err, qual_out}, 32'd0);

        // R2: sweep all patterns on the direct path
        sel_direct = 4'hF;
        prev = 4'h0;
        for (int p = 0; p < 16; p++) begin
            raw_in = p[3:0];
            tick(1);
            check("R2 one edge later still old", {28'd0, qual_out}, {28'd0, prev});
            tick(1);
            check("R2 two edges later new", {28'd0, qual_out}, p);
            prev = p[3:0];
        end
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        check("R9 clear", {31'd0, phase_err}, 32'd0);

        // Phase error tests on direct path
        raw_in = 4'h0; tick(4);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        raw_in = 4'b0011;
        tick(2);
        check("R8 not yet set", {31'd0, phase_err}, 32'd0);
        tick(1);
        check("R8 set after simultaneous A/B", {31'd0, phase_err}, 32'd1);
        tick(3);
        check("R9 sticky", {31'd0, phase_err}, 32'd1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        check("R9 cleared by pulse", {31'd0, phase_err}, 32'd0);
        raw_in = 4'b0010; tick(4);
        check("R10 A alone", {31'd0, phase_err}, 32'd0);
        raw_in = 4'b0000; tick(4);
        check("R10 B alone later", {31'd0, phase_err}, 32'd0);
        raw_in = 4'b1100; tick(4);
        check("R10 index and strobe", {31'd0, phase_err}, 32'd0);
        raw_in = 4'b0011;
        tick(2);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        check("R9 set wins over clear", {31'd0, phase_err}, 32'd1);
        raw_in = 4'b0000; tick(4);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        check("R9 clear after second error", {31'd0, phase_err}, 32'd0);

        // R6/R4: filter sweep on index channel
        sel_direct = 4'h0; sel_filter = 4'hF; raw_in = 4'h0;
        tick(20);
        for (int w = 1; w <= 6; w++) begin
            for (int len = 1; len <= w + 1; len++) begin
                filt_width = w[7:0];
                raw_in[2] = 1'b1;
                for (int c = 1; c <= 2 * w + len + 4; c++) begin
                    tick(1);
                    if (c == w + 1)
                        check("R6 filtered not early", {31'd0, qual_out[2]}, 32'd0);
                    if (c == w + 2)
                        check("R4 R6 filtered pass or reject", {31'd0, qual_out[2]}, {31'd0, len >= w});
                    if (c == len) raw_in[2] = 1'b0;
                end
                check("R6 filtered returns low", {28'd0, qual_out}, 32'd0);
            end
        end
        check("R10 no error from index", {31'd0, phase_err}, 32'd0);

        // R7: width 0 behaves as width 1
        filt_width = 8'd0;
        raw_in[3] = 1'b1;
        tick(1); raw_in[3] = 1'b0;
        tick(1);
        check("R7 width0 not early", {31'd0, qual_out[3]}, 32'd0);
        tick(1);
        check("R7 width0 passes one-cycle pulse", {31'd0, qual_out[3]}, 32'd1);
        tick(6);

        // R3: primary overrides secondary
        sel_direct = 4'hF; sel_filter = 4'hF; filt_width = 8'd10;
        raw_in = 4'b0100;
        tick(1); raw_in = 4'h0;
        tick(1);
        check("R3 direct wins, pulse seen", {28'd0, qual_out}, 32'h4);
        tick(1);
        check("R3 pulse gone", {28'd0, qual_out}, 32'h0);
        tick(12);

        // R5: both selects 0
        sel_direct = 4'h0; sel_filter = 4'h0; filt_width = 8'd1;
        raw_in = 4'hF; tick(6);
        check("R5 off channels low", {28'd0, qual_out}, 32'h0);
        raw_in = 4'h0; tick(6);

        // R11: mixed modes per channel
        sel_direct = 4'b0001; sel_filter = 4'b0100; filt_width = 8'd3;
        tick(8);
        raw_in = 4'hF;
        tick(2);
        check("R11 direct channel first", {28'd0, qual_out}, 32'b0001);
        tick(2);
        check("R11 filtered not yet", {28'd0, qual_out}, 32'b0001);
        tick(1);
        check("R11 filtered after 2+W", {28'd0, qual_out}, 32'b0101);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule